// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a small serial memory. It oversamples the two wire lines (serial clock and serial data) with a fast system clock. It spots start and stop conditions and takes in an address byte. When that byte names this device, the block acknowledges it. It then either receives a word pointer and data bytes, or streams data bytes back to the master. The storage array sits outside the block. The block gives it a one-cycle write request per received byte, and a one-cycle read request per byte it is about to transmit. Read data must come back on the cycle after the read request.

The serial data pad is modelled as open drain. The block never drives a high level. It raises `sda_oe_o` to pull the line low, and it reads the resolved line back on `sda_i`. Both line inputs pass through a synchronizer chain before any decoding.

The controller has nine named states:

- `S_IDLE` waits for a start.
- `S_DEV` shifts in the address byte.
- `S_DEV_ACK` acknowledges it.
- `S_WADR` and `S_WADR_ACK` take in the word pointer and acknowledge it.
- `S_WDAT` and `S_WDAT_ACK` take in each data byte and acknowledge it.
- `S_RDAT` transmits a byte.
- `S_RACK` listens for the master's acknowledge.

The transitions are:

- A start moves any state to `S_DEV`.
- A stop moves any state to `S_IDLE`.
- `S_DEV` goes to `S_DEV_ACK` on a match, or back to `S_IDLE` on a mismatch.
- `S_DEV_ACK` goes to `S_RDAT` for a read or to `S_WADR` for a write.
- `S_WADR` goes to `S_WADR_ACK`, and `S_WADR_ACK` goes to `S_WDAT`.
- `S_WDAT` goes to `S_WDAT_ACK`, and `S_WDAT_ACK` returns to `S_WDAT`.
- `S_RDAT` goes to `S_RACK`.
- `S_RACK` goes back to `S_RDAT` on an acknowledge, or to `S_IDLE` on a not-acknowledge.

Top module: `twm_slave`

## Requirements
- R1: Reset leaves the engine idle: `sda_oe_o`, `wr_req_o` and `rd_req_o` are all 0.
- R2: A start is data falling while the clock is high, and a stop is data rising while the clock is high. Clocked bits seen before any start get no acknowledge and cause no request.
- R3: The first byte after a start is taken most significant bit first. If it equals binary 1010, then `strap_i[2:1:0]`, then a direction bit, the line is pulled low for the whole ninth clock. Otherwise the line stays released for that byte and all later bytes until the next start.
- R4: A direction bit of 0 selects write. The next byte is acknowledged, and its low ADDR_W bits load the word pointer; its upper bits are ignored.
- R5: In write mode every further full byte is acknowledged. It raises `wr_req_o` for exactly one cycle with `wr_addr_o` equal to the pointer and `wr_data_o` equal to the byte. The pointer then steps by one and wraps modulo 2^ADDR_W.
- R6: A direction bit of 1 selects read. The slave sends the byte at the pointer, most significant bit first, with 1 meaning released and 0 meaning pulled low. It releases the line on the ninth clock. Each byte costs one single-cycle `rd_req_o` at `rd_addr_o` equal to the pointer, and the pointer then steps with wrap.
- R7: A master acknowledge (line low on the ninth clock) makes the slave send the byte at the next pointer. A not-acknowledge ends the transfer: the line stays released and no read request is issued until the next start.
- R8: A stop in any state, including mid-byte, returns the engine to idle with the line released. A partial byte produces no write request.
- R9: A repeated start in any state restarts the address phase. This lets a write that only sets the pointer be followed directly by a read from that pointer.
- R10: `sda_oe_o` changes only while the synchronized clock is low. It stays stable across each clock-high interval.
- R11: `wr_req_o` and `rd_req_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Resolved serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 3 | Device select straps, compared with address bits 3:1 |
| wr_req_o | output | 1 | One-cycle byte write request |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | 8 | Write data |
| rd_req_o | output | 1 | One-cycle byte read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_i | input | 8 | Read data, valid the cycle after `rd_req_o` |

## Verification
The bench builds the engine with ADDR_W = 4 and two synchronizer stages. A sixteen-byte array is then enough to show pointer wrap within short bursts, and to show that the upper bits of a word pointer byte are dropped. The serial clock half period is ten system cycles. This leaves room for the synchronizer, the edge detector, the read latency and the registered pad enable to settle within the low phase, which is what R10 depends on.

// File: rtl/twm_pkg.sv
package twm_pkg;
    localparam int          BYTE_W   = 8;
    localparam logic [3:0]  DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_WADR,
        S_WADR_ACK,
        S_WDAT,
        S_WDAT_ACK,
        S_RDAT,
        S_RACK
    } state_t;
endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/twm_cond.sv
module twm_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twm_slave.sv
module twm_slave
    import twm_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        strap_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [BYTE_W-1:0] rd_data_i
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    // line synchronizers: index 0 is data, index 1 is clock
    logic [1:0] raw_lines, sync_lines;
    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        twm_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (raw_lines[g]),
            .q_o   (sync_lines[g])
        );
    end

    logic scl_s, sda_s;
    assign scl_s = sync_lines[1];
    assign sda_s = sync_lines[0];

    logic scl_rise, scl_fall, start_ev, stop_ev;

    twm_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    state_t             state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [BYTE_W-1:0]  shift_q, tx_q, wdata_q;
    logic [ADDR_W-1:0]  ptr_q, req_addr_q;
    logic               rw_q, mack_q, rd_pend_q;
    logic               wr_req_q, rd_req_q, oe_d, oe_q;
    logic               addr_hit, rx_state, byte_done;

    assign addr_hit  = (shift_q[7:1] == {DEV_TYPE, strap_i});
    assign rx_state  = (state_q == S_DEV) || (state_q == S_WADR) || (state_q == S_WDAT);
    assign byte_done = scl_fall && (cnt_q == CNT_W'(BYTE_W));

    // next state
    always_comb begin
        state_d = state_q;
        if (start_ev) begin
            state_d = S_DEV;
        end else if (stop_ev) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:     state_d = S_IDLE;
                S_DEV:      if (byte_done) state_d = addr_hit ? S_DEV_ACK : S_IDLE;
                S_DEV_ACK:  if (scl_fall)  state_d = rw_q ? S_RDAT : S_WADR;
                S_WADR:     if (byte_done) state_d = S_WADR_ACK;
                S_WADR_ACK: if (scl_fall)  state_d = S_WDAT;
                S_WDAT:     if (byte_done) state_d = S_WDAT_ACK;
                S_WDAT_ACK: if (scl_fall)  state_d = S_WDAT;
                S_RDAT:     if (scl_fall && cnt_q == CNT_W'(BYTE_W - 1)) state_d = S_RACK;
                S_RACK:     if (scl_fall)  state_d = mack_q ? S_RDAT : S_IDLE;
                default:    state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            shift_q    <= '0;
            tx_q       <= '1;
            wdata_q    <= '0;
            ptr_q      <= '0;
            req_addr_q <= '0;
            rw_q       <= 1'b0;
            mack_q     <= 1'b0;
            rd_pend_q  <= 1'b0;
            wr_req_q   <= 1'b0;
            rd_req_q   <= 1'b0;
        end else begin
            wr_req_q  <= 1'b0;
            rd_req_q  <= 1'b0;
            rd_pend_q <= rd_req_q;

            if (state_d != state_q || start_ev) begin
                cnt_q <= '0;
            end else if (scl_rise && rx_state) begin
                shift_q <= {shift_q[BYTE_W-2:0], sda_s};
                cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall && state_q == S_RDAT) begin
                tx_q  <= {tx_q[BYTE_W-2:0], 1'b1};
                cnt_q <= cnt_q + 1'b1;
            end

            if (state_q == S_DEV && state_d == S_DEV_ACK)
                rw_q <= shift_q[0];
            if (state_q == S_WADR && state_d == S_WADR_ACK)
                ptr_q <= shift_q[ADDR_W-1:0];
            if (state_q == S_WDAT && state_d == S_WDAT_ACK) begin
                wr_req_q   <= 1'b1;
                req_addr_q <= ptr_q;
                wdata_q    <= shift_q;
                ptr_q      <= ptr_q + 1'b1;
            end
            if ((state_q == S_DEV_ACK || state_q == S_RACK) && state_d == S_RDAT) begin
                rd_req_q   <= 1'b1;
                req_addr_q <= ptr_q;
                ptr_q      <= ptr_q + 1'b1;
            end
            if (state_q == S_RACK && scl_rise)
                mack_q <= ~sda_s;
            if (rd_pend_q)
                tx_q <= rd_data_i;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            S_DEV_ACK, S_WADR_ACK, S_WDAT_ACK: oe_d = 1'b1;
            S_RDAT:                            oe_d = ~tx_q[BYTE_W-1];
            default:                           oe_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= oe_d;
    end

    assign sda_oe_o  = oe_q;
    assign wr_req_o  = wr_req_q;
    assign wr_addr_o = req_addr_q;
    assign wr_data_o = wdata_q;
    assign rd_req_o  = rd_req_q;
    assign rd_addr_o = req_addr_q;
endmodule

// File: rtl/twm_slave_chk.sv
module twm_slave_chk
    import twm_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   scl_s,
    input logic   stop_ev,
    input logic   sda_oe,
    input logic   wr_req,
    input logic   rd_req,
    input state_t state
);
    a_r10_oe_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    a_r11_no_dual_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && rd_req));

    a_r5_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req);

    a_r5_wr_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (state == S_WDAT_ACK));

    a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    a_r6_rd_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (state == S_RDAT));

    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == S_IDLE));
endmodule

bind twm_slave twm_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .stop_ev (stop_ev),
    .sda_oe  (sda_oe_o),
    .wr_req  (wr_req_o),
    .rd_req  (rd_req_o),
    .state   (state_q)
);

// File: tb/twm_slave_tb.sv
module twm_slave_tb;
    localparam int AW   = 4;
    localparam int H    = 10;
    localparam int MEMN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_scl = 1'b1, m_sda = 1'b1;
    logic          sda_oe;
    logic [2:0]    strap = 3'b101;
    logic          wr_req, rd_req;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [7:0]    wr_data, rd_data;
    logic          sda_line;

    logic [7:0] mem     [MEMN];
    logic [7:0] ref_mem [MEMN];
    int wr_cnt = 0, rd_cnt = 0;
    int n_chk = 0, n_fail = 0;

    assign sda_line = m_sda & ~sda_oe;

    always #2 clk = ~clk;

    twm_slave #(.ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe_o  (sda_oe),
        .strap_i   (strap),
        .wr_req_o  (wr_req),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .rd_req_o  (rd_req),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data)
    );

    // memory-side model: registered read, one-cycle write
    always @(posedge clk) begin
        if (rd_req) begin
            rd_data <= mem[rd_addr];
            rd_cnt  <= rd_cnt + 1;
        end
        if (wr_req) begin
            mem[wr_addr] <= wr_data;
            wr_cnt       <= wr_cnt + 1;
        end
    end

    function automatic logic [7:0] dev_byte(input logic [2:0] s, input logic rd);
        return {4'b1010, s, rd};
    endfunction

    function automatic int wrap_idx(input int a, input int i);
        return (a + i) % MEMN;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        wait_n(2); m_sda = 1'b1; wait_n(H);
        m_scl = 1'b1; wait_n(H);
        m_sda = 1'b0; wait_n(H);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(2); m_sda = 1'b0; wait_n(H);
        m_scl = 1'b1; wait_n(H);
        m_sda = 1'b1; wait_n(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            wait_n(2); m_sda = b[i]; wait_n(H);
            m_scl = 1'b1; wait_n(H);
            m_scl = 1'b0;
        end
    endtask

    // sends a byte, returns 1 when the slave acknowledged
    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic mid, late;
        send_bits(b, 8);
        wait_n(2); m_sda = 1'b1; wait_n(H);
        m_scl = 1'b1; wait_n(H / 2);
        mid = sda_line; wait_n(H - H / 2 - 1);
        late = sda_line; wait_n(1);
        m_scl = 1'b0;
        acked = !mid;
        chk(mid == late, "R10", late, mid);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            wait_n(2); m_sda = 1'b1; wait_n(H);
            m_scl = 1'b1; wait_n(H / 2);
            b = {b[6:0], sda_line}; wait_n(H - H / 2);
            m_scl = 1'b0;
        end
        wait_n(2); m_sda = !give_ack; wait_n(H);
        m_scl = 1'b1; wait_n(H);
        m_scl = 1'b0; wait_n(2);
        m_sda = 1'b1;
    endtask

    task automatic write_burst(input logic [7:0] wa, input int n);
        bit a;
        int base;
        logic [7:0] d;
        base = wr_cnt;
        bus_start();
        send_byte(dev_byte(strap, 1'b0), a); chk(a, "R3", a, 1);
        send_byte(wa, a);                     chk(a, "R4", a, 1);
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, a); chk(a, "R5", a, 1);
            ref_mem[wrap_idx(int'(wa) % MEMN, i)] = d;
        end
        bus_stop();
        chk(wr_cnt - base == n, "R5", wr_cnt - base, n);
    endtask

    task automatic read_burst(input logic [7:0] ra, input int n, input bit extra);
        bit a;
        int base;
        logic [7:0] got;
        base = rd_cnt;
        bus_start();
        send_byte(dev_byte(strap, 1'b0), a); chk(a, "R3", a, 1);
        send_byte(ra, a);                     chk(a, "R4", a, 1);
        bus_start();
        send_byte(dev_byte(strap, 1'b1), a); chk(a, "R9", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, got);
            chk(got == ref_mem[wrap_idx(int'(ra) % MEMN, i)], i == 0 ? "R6" : "R7",
                got, ref_mem[wrap_idx(int'(ra) % MEMN, i)]);
        end
        if (extra) begin
            recv_byte(1'b0, got);
            chk(got == 8'hFF, "R7", got, 8'hFF);
        end
        bus_stop();
        chk(rd_cnt - base == n, "R7", rd_cnt - base, n);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        bit a;
        int base;
        for (int i = 0; i < MEMN; i++) begin
            mem[i] = 8'h00;
            ref_mem[i] = 8'h00;
        end
        void'($urandom(32'd4242));
        wait_n(5);
        chk(sda_oe == 0 && wr_req == 0 && rd_req == 0, "R1",
            {sda_oe, wr_req, rd_req}, 0);
        rst_n = 1'b1;
        wait_n(5);

        // R2: bytes clocked before any start are ignored
        m_scl = 1'b0;
        base = wr_cnt + rd_cnt;
        send_byte(dev_byte(strap, 1'b0), a); chk(!a, "R2", a, 0);
        send_byte(8'h03, a);                  chk(!a, "R2", a, 0);
        chk(wr_cnt + rd_cnt == base, "R2", wr_cnt + rd_cnt, base);

        // R3: mismatching straps get no acknowledge
        bus_start();
        send_byte(dev_byte(3'b011, 1'b0), a); chk(!a, "R3", a, 0);
        send_byte(8'h02, a);                   chk(!a, "R3", a, 0);
        bus_stop();
        chk(sda_oe == 0, "R8", sda_oe, 0);

        // R3: mismatching device type
        bus_start();
        send_byte({4'b1011, strap, 1'b0}, a); chk(!a, "R3", a, 0);
        bus_stop();

        // R4, R5, R6: byte write then read back
        write_burst(8'h06, 1);
        read_burst(8'h06, 1, 1'b0);

        // R4: upper pointer bits ignored
        write_burst(8'hB3, 2);
        read_burst(8'h03, 2, 1'b0);

        // R5: pointer wraps
        write_burst(8'h0E, 4);
        read_burst(8'h0E, 4, 1'b0);

        // R7: not-acknowledge ends the stream
        read_burst(8'h0F, 2, 1'b1);

        // R8: stop mid-byte writes nothing
        base = wr_cnt;
        bus_start();
        send_byte(dev_byte(strap, 1'b0), a); chk(a, "R3", a, 1);
        send_byte(8'h05, a);                  chk(a, "R4", a, 1);
        send_bits(8'hA5, 4);
        wait_n(2); m_scl = 1'b0;
        bus_stop();
        chk(wr_cnt == base, "R8", wr_cnt, base);
        chk(sda_oe == 0, "R8", sda_oe, 0);
        read_burst(8'h05, 1, 1'b0);

        // R9: repeated start mid address byte restarts the address phase
        bus_start();
        send_bits(dev_byte(strap, 1'b0), 3);
        bus_start();
        send_byte(dev_byte(strap, 1'b0), a); chk(a, "R9", a, 1);
        bus_stop();

        // random bursts
        for (int t = 0; t < 6; t++) begin
            logic [7:0] ra;
            int nn;
            ra = 8'($urandom);
            nn = 1 + int'($urandom % 5);
            write_burst(ra, nn);
            read_burst(ra, nn, 1'b0);
        end

        wait_n(10);
        finish_run();
    end
endmodule